// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a root-complex host bus and the memory-mapped register fabric of a PCIe controller. It accepts one configuration read or write at a time. Each request names a bus number, device, function, register offset and access size. The block steers the request to one of two places:

- Requests for the root bus go straight to the controller's own configuration registers.
- Requests for any other bus first program a target-selection register in the application register block. The access then goes into a remote configuration window that the controller turns into a link-side configuration cycle.

The bus number also chooses the cycle type in that selection word. The bus directly below the root port is a virtual secondary bus, so it takes Type 0 cycles. Every bus beyond it takes Type 1 cycles.

The fabric side is a simple request/acknowledge port. Each fabric access is offered on `fab_req` and held until `fab_ack`. The block always uses dword-aligned addresses. On reads, the block extracts the addressed byte, halfword or dword from the returned dword. Writes carry the host's data dword unchanged. Merging of sub-dword write lanes is left to the fabric. The host sees `busy` while a request is in flight and a one-cycle `rsp_valid` when it completes.

Top module: `cfg_access_router`

## Requirements
- R1: A request with bus number 0 produces exactly one fabric access, at LOCAL_BASE + (offset with bits 1:0 cleared), and no write to the selection register.
- R2: A request with a non-zero bus first writes the selection register at APP_BASE + 0x008 with fab_we=1. The written word carries the bus number in bits 23:16, the 5-bit device in bits 12:8 and the 3-bit function in bits 2:0. Bits 31:25, 15:13 and 7:3 are zero.
- R3: Bit 24 of the selection word is 1 (Type 1) for every non-zero bus except bus 1. For bus 1 it is 0 (Type 0).
- R4: After the selection write, a non-zero-bus request makes one fabric access at LOCAL_BASE + 0x1000 + (offset with bits 1:0 cleared).
- R5: Every fabric address has bits 1:0 equal to zero, whatever the low bits of the request offset.
- R6: The selection write is acknowledged before the window access is offered. While fab_req is high and fab_ack is low, fab_addr, fab_we and fab_wdata stay stable.
- R7: busy rises in the cycle after a request is accepted and stays high until the response. A req_valid seen while busy is ignored: it starts no fabric access and does not change the response.
- R8: rsp_valid is high for exactly one cycle per accepted request, after the last fabric acknowledge.
- R9: For reads, rsp_rdata is the returned dword shifted right by 8 × offset[1:0], then masked to the size. req_size 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. Unused upper bits are zero.
- R10: For writes, the data access has fab_we=1 and fab_wdata equal to req_wdata, and rsp_rdata is zero. Reads have fab_we=0 on the data access.
- R11: After reset, busy, fab_req and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken when busy is low |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | OFF_W (12) | Register byte offset |
| req_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| req_wdata | input | 32 | Write data dword |
| busy | output | 1 | Request in flight |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Aligned read data (zero for writes) |
| fab_req | output | 1 | Fabric access request, held until acknowledged |
| fab_we | output | 1 | Fabric write enable |
| fab_addr | output | ADDR_W (32) | Fabric byte address, dword aligned |
| fab_wdata | output | 32 | Fabric write data |
| fab_ack | input | 1 | Fabric acknowledge |
| fab_rdata | input | 32 | Fabric read data, valid with fab_ack |

## Verification
Directed requests cover the three routing classes: bus 0, bus 1 and buses above 1. They also include bus 255 and the largest device and function numbers. Each class is told apart by how many fabric accesses it makes, by the target address and by bit 24 of the selection word. Reads use all four byte offsets within a dword and all size codes, which separates the shift from the mask. Random requests mix reads and writes with random acknowledge latency, which exercises hold-until-acknowledge ordering. One request carries an extra strobe while busy, to show that it leaves no trace on the fabric.

// File: rtl/cfg_rtr_pkg.sv
// Package: shared state encoding and size codes for the configuration router.
// Assumes a single outstanding request at any time.
package cfg_rtr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RESP   = 2'd3
    } rtr_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/cfg_route_decode.sv
// Route decoder: classifies a request as local or remote, builds the
// target-selection word and the dword-aligned access address.
// Assumes BUS_W <= 8, DEV_W <= 8, FN_W <= 8 and DATA_W >= 25.
module cfg_route_decode #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned DEV_W      = 5,
    parameter int unsigned FN_W       = 3,
    parameter int unsigned OFF_W      = 12,
    parameter logic [31:0] LOCAL_BASE = 32'h0100_0000,
    parameter logic [31:0] REMOTE_OFS = 32'h0000_1000
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    output logic              is_local,
    output logic [DATA_W-1:0] sel_word,
    output logic [ADDR_W-1:0] access_addr
);
    localparam logic [ADDR_W-1:0] LOC_A = ADDR_W'(LOCAL_BASE);
    localparam logic [ADDR_W-1:0] REM_A = ADDR_W'(LOCAL_BASE + REMOTE_OFS);

    logic [ADDR_W-1:0] aligned_off;

    // Root bus is served by the local register space.
    assign is_local = (bus == '0);

    // Clear the two low offset bits to get a dword-aligned offset.
    assign aligned_off = ADDR_W'({off[OFF_W-1:2], 2'b00});

    // Select the base for the target space and add the aligned offset.
    assign access_addr = (is_local ? LOC_A : REM_A) + aligned_off;

    // Pack bus, device, function and cycle type into the selection word.
    always_comb begin
        sel_word               = '0;
        sel_word[16 +: BUS_W]  = bus;
        sel_word[8 +: DEV_W]   = dev;
        sel_word[0 +: FN_W]    = fn;
        sel_word[24]           = (bus != BUS_W'(1));
    end
endmodule

// File: rtl/cfg_rd_align.sv
// Read aligner: moves the addressed lane of a returned dword down to bit 0
// and clears the bytes beyond the access size.
// Assumes DATA_W = 32 and size codes from cfg_rtr_pkg.
module cfg_rd_align #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] dword,
    input  logic [1:0]        byte_sel,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data
);
    import cfg_rtr_pkg::*;

    logic [DATA_W-1:0] shifted;

    // Shift the addressed byte lane down to bit 0.
    assign shifted = dword >> {byte_sel, 3'b000};

    // Mask to the requested size.
    always_comb begin
        case (size)
            SZ_BYTE: data = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            SZ_HALF: data = {{(DATA_W-16){1'b0}}, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/cfg_access_router.sv
// Configuration access router top. It accepts one host request, optionally
// writes the target-selection register, then performs the data access and
// returns a one-cycle response.
// Assumes the fabric holds fab_rdata valid while fab_ack is high.
module cfg_access_router #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BUS_W      = 8,
    parameter int unsigned DEV_W      = 5,
    parameter int unsigned FN_W       = 3,
    parameter int unsigned OFF_W      = 12,
    parameter logic [31:0] LOCAL_BASE = 32'h0100_0000,
    parameter logic [31:0] APP_BASE   = 32'h0210_0000,
    parameter logic [31:0] SEL_OFS    = 32'h0000_0008,
    parameter logic [31:0] REMOTE_OFS = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fab_req,
    output logic              fab_we,
    output logic [ADDR_W-1:0] fab_addr,
    output logic [DATA_W-1:0] fab_wdata,
    input  logic              fab_ack,
    input  logic [DATA_W-1:0] fab_rdata
);
    import cfg_rtr_pkg::*;

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(APP_BASE + SEL_OFS);

    rtr_state_t        state_q;
    logic              wr_q;
    logic [BUS_W-1:0]  bus_q;
    logic [DEV_W-1:0]  dev_q;
    logic [FN_W-1:0]   fn_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] wdata_q;

    logic              is_local;
    logic [DATA_W-1:0] sel_word;
    logic [ADDR_W-1:0] access_addr;
    logic [DATA_W-1:0] rd_aligned;

    cfg_route_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .DEV_W(DEV_W),
        .FN_W(FN_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE),
        .REMOTE_OFS(REMOTE_OFS)
    ) i_decode (
        .bus(bus_q), .dev(dev_q), .fn(fn_q), .off(off_q),
        .is_local(is_local), .sel_word(sel_word), .access_addr(access_addr)
    );

    cfg_rd_align #(.DATA_W(DATA_W)) i_align (
        .dword(fab_rdata), .byte_sel(off_q[1:0]), .size(size_q),
        .data(rd_aligned)
    );

    // Sequence: accept, optional selection write, data access, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wr_q      <= 1'b0;
            bus_q     <= '0;
            dev_q     <= '0;
            fn_q      <= '0;
            off_q     <= '0;
            size_q    <= '0;
            wdata_q   <= '0;
            rsp_rdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    bus_q   <= req_bus;
                    dev_q   <= req_dev;
                    fn_q    <= req_fn;
                    off_q   <= req_off;
                    size_q  <= req_size;
                    wdata_q <= req_wdata;
                    state_q <= (req_bus == '0) ? ST_ACCESS : ST_SETUP;
                end
                ST_SETUP: if (fab_ack) state_q <= ST_ACCESS;
                ST_ACCESS: if (fab_ack) begin
                    rsp_rdata <= wr_q ? '0 : rd_aligned;
                    state_q   <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Host-side status decoded from the sequencer state.
    assign busy      = (state_q != ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // Fabric port: selection write in SETUP, data access in ACCESS.
    always_comb begin
        fab_req   = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        fab_we    = (state_q == ST_SETUP) ? 1'b1 : wr_q;
        fab_addr  = (state_q == ST_SETUP) ? SEL_ADDR : access_addr;
        fab_wdata = (state_q == ST_SETUP) ? sel_word : wdata_q;
    end

    AST_LOCAL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fab_req && (fab_addr == SEL_ADDR) |-> (bus_q != '0)); // R1
    AST_SEL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (fab_wdata[31:25] == '0) && (fab_wdata[15:13] == '0)
                                  && (fab_wdata[7:3] == '0) && fab_we); // R2
    AST_CYCLE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> (fab_wdata[24] == (bus_q != BUS_W'(1)))); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fab_req |-> (fab_addr[1:0] == 2'b00)); // R5
    AST_FAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fab_req && !fab_ack |=> fab_req && $stable(fab_addr) && $stable(fab_wdata)
                                && $stable(fab_we)); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid |=> $stable(bus_q) && $stable(off_q) && $stable(wr_q)); // R7
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;
    localparam logic [31:0] LBASE = 32'h0100_0000;
    localparam logic [31:0] SADDR = 32'h0210_0008;
    localparam logic [31:0] RBASE = 32'h0100_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, fab_req, fab_we;
    logic [31:0] rsp_rdata, fab_addr, fab_wdata;
    logic        fab_ack = 1'b0;
    logic [31:0] fab_rdata = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // fabric log
    int          nlog = 0;
    logic [31:0] lg_addr [4];
    logic [31:0] lg_data [4];
    logic        lg_we   [4];
    logic [31:0] last_rd;
    int          dly = 0;

    cfg_access_router i_cfg_access_router (
        .clk, .rst_n, .req_valid, .req_write, .req_bus, .req_dev, .req_fn,
        .req_off, .req_size, .req_wdata, .busy, .rsp_valid, .rsp_rdata,
        .fab_req, .fab_we, .fab_addr, .fab_wdata, .fab_ack, .fab_rdata
    );

    always #4 clk = ~clk;

    // fabric responder with random latency
    always @(negedge clk) begin
        if (fab_ack) fab_ack = 1'b0;
        else if (fab_req) begin
            if (dly == 0) begin
                if (nlog < 4) begin
                    lg_addr[nlog] = fab_addr;
                    lg_data[nlog] = fab_wdata;
                    lg_we[nlog]   = fab_we;
                end
                nlog++;
                fab_rdata = $urandom;
                last_rd   = fab_rdata;
                fab_ack   = 1'b1;
                dly       = $urandom % 4;
            end else dly--;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sel(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f);
        return {7'b0, (b != 8'd1), b, 3'b0, d, 5'b0, f};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] dw, input logic [1:0] lo,
                                           input logic [1:0] sz);
        logic [31:0] s;
        s = dw >> (8 * lo);
        if (sz == 2'd0) return s & 32'hFF;
        if (sz == 2'd1) return s & 32'hFFFF;
        return s;
    endfunction

    task automatic run(input bit wr, input logic [7:0] b, input logic [4:0] d,
                       input logic [2:0] f, input logic [11:0] o, input logic [1:0] sz,
                       input logic [31:0] wd, input bit poke);
        int ai;
        logic [31:0] eaddr;
        nlog = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = b; req_dev = d; req_fn = f;
        req_off = o; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R7 busy after accept", {31'b0, busy}, 32'd1);
        if (poke) begin
            req_valid = 1'b1; req_bus = 8'd0; req_off = 12'h040; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int k = 0; k < 100 && !rsp_valid; k++) @(negedge clk);
        chk(rsp_valid === 1'b1, "R8 response seen", {31'b0, rsp_valid}, 32'd1);
        ai = (b == 8'd0) ? 0 : 1;
        eaddr = ((b == 8'd0) ? LBASE : RBASE) + {20'b0, o[11:2], 2'b00};
        chk(nlog == ai + 1, "R1/R4 access count", nlog, ai + 1);
        if (nlog == ai + 1) begin
            if (ai == 1) begin
                chk(lg_addr[0] == SADDR && lg_we[0], "R2 selection address", lg_addr[0], SADDR);
                chk(lg_data[0] == exp_sel(b, d, f), "R2/R3 selection word", lg_data[0],
                    exp_sel(b, d, f));
            end
            chk(lg_addr[ai] == eaddr, (ai == 1) ? "R4/R5 window address" : "R1/R5 local address",
                lg_addr[ai], eaddr);
            chk(lg_we[ai] == wr, "R10 access direction", {31'b0, lg_we[ai]}, {31'b0, wr});
            if (wr) begin
                chk(lg_data[ai] == wd, "R10 write data", lg_data[ai], wd);
                chk(rsp_rdata == 32'h0, "R10 write response", rsp_rdata, 32'h0);
            end else
                chk(rsp_rdata == exp_rd(last_rd, o[1:0], sz), "R9 read data", rsp_rdata,
                    exp_rd(last_rd, o[1:0], sz));
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0 && busy === 1'b0, "R8 one-cycle response", {31'b0, rsp_valid},
            32'd0);
        repeat (2) @(negedge clk);
        chk(nlog == ai + 1 && !fab_req, "R7 no stray access", nlog, ai + 1);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk(!busy && !fab_req && !rsp_valid, "R11 reset state",
            {29'b0, busy, fab_req, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // directed corners
        run(1'b0, 8'd0,   5'd3,  3'd1, 12'h0FF, 2'd0, 32'h0, 1'b0);   // R1 R9
        run(1'b0, 8'd1,   5'd0,  3'd0, 12'h102, 2'd1, 32'h0, 1'b0);   // R3 Type 0
        run(1'b1, 8'd5,   5'd7,  3'd2, 12'h010, 2'd2, 32'hCAFE_F00D, 1'b0); // R10
        run(1'b0, 8'd255, 5'd31, 3'd7, 12'h003, 2'd2, 32'h0, 1'b0);   // R2 R5
        run(1'b0, 8'd2,   5'd1,  3'd0, 12'h001, 2'd0, 32'h0, 1'b0);   // R9 lane 1
        run(1'b0, 8'd3,   5'd9,  3'd4, 12'h00E, 2'd3, 32'h0, 1'b0);   // R9 size 3
        run(1'b1, 8'd1,   5'd2,  3'd3, 12'h020, 2'd2, 32'h1234_5678, 1'b1); // R7 poke
        run(1'b0, 8'd0,   5'd0,  3'd0, 12'h7FD, 2'd1, 32'h0, 1'b1);   // R7 poke local
        for (int i = 0; i < 200; i++) begin
            logic [7:0] b;
            b = $urandom % 4 == 0 ? 8'($urandom % 2) : 8'($urandom);
            run(1'($urandom), b, 5'($urandom), 3'($urandom), 12'($urandom),
                2'($urandom), $urandom, 1'b0);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule